// File: doc/BRIEF.md
# Age-Prioritized Deflection Switch Allocator

This block decides, every cycle, where each flit in a bufferless mesh router goes. Up to four flits arrive on the network links and one more may be offered by the local node. Since the router has no storage, every flit accepted in a cycle leaves on some output in the next cycle. Each flit carries its own destination coordinates and an age stamp. The block compares the destination with the router's own position to find the productive directions. It then sorts the flits by age, assigns outputs in that order, and sends any flit whose wishes are already taken to the lowest-numbered free network port. This deflection is what keeps the router from ever having to hold a flit.

A mode input picks between single-direction routing (X first, then Y) and multi-direction routing, in which a flit may take either of its two productive directions. Flits addressed to this router ask for the ejection port, and only one of them may eject per cycle. At the edges of the mesh, ports that lead outside are never used. A local flit is taken only while a network output is certain to stay free.

Top module: `defl_switch_alloc`

## Requirements
- R1: Every valid flit on an in-mesh link, and the local flit when accepted, appears on exactly one output in the following cycle; no output carries two flits, and the number of valid outputs equals the number of accepted flits.
- R2: Output port numbering is N=0, E=1, S=2, W=3, eject=4. Destination x greater than own x is productive toward E, smaller toward W; destination y greater than own y is productive toward N, smaller toward S; equal in both asks for eject.
- R3: With `cfg_multi`=0 a flit asks only for its X direction while x differs, and only for its Y direction once x matches.
- R4: With `cfg_multi`=1 a flit asks for both productive directions and takes the X direction if it is free, else the Y direction if free.
- R5: Flits are served in order of larger age first; equal ages are ordered by input index (N=0, E=1, S=2, W=3, local=4, lower first).
- R6: A flit that finds none of its requested ports free takes the lowest-numbered free in-mesh network port (order N, E, S, W).
- R7: At most one flit ejects per cycle; of the flits addressed to this router, the first in the R5 order ejects and the others are deflected onto network ports.
- R8: `inj_ready` is high, in the same cycle, exactly when the count of valid in-mesh link flits is below the count of in-mesh links; a local flit offered while `inj_ready` is low is not forwarded.
- R9: Links leave the mesh as follows: N when own y is MESH_Y-1, S when own y is 0, E when own x is MESH_X-1, W when own x is 0; those outputs are never valid and flits on those inputs are ignored.
- R10: An output carries the flit's destination and payload unchanged and its age plus one, holding at the maximum value 2^AGE_W-1.
- R11: Outputs are registered: results appear one clock after the inputs, and reset clears all output valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_multi | input | 1 | 1 = multi-direction routing, 0 = X-then-Y |
| pos_x | input | XW | Router x coordinate |
| pos_y | input | YW | Router y coordinate |
| lnk_valid | input | 4 | Valid per incoming link (N,E,S,W) |
| lnk_dx | input | 4 x XW | Destination x per link |
| lnk_dy | input | 4 x YW | Destination y per link |
| lnk_age | input | 4 x AGE_W | Age stamp per link |
| lnk_data | input | 4 x DATA_W | Payload per link |
| inj_valid | input | 1 | Local flit offered |
| inj_dx | input | XW | Local flit destination x |
| inj_dy | input | YW | Local flit destination y |
| inj_age | input | AGE_W | Local flit age |
| inj_data | input | DATA_W | Local flit payload |
| inj_ready | output | 1 | Local flit accepted this cycle |
| out_valid | output | 5 | Valid per output (N,E,S,W,eject) |
| out_dx | output | 5 x XW | Destination x per output |
| out_dy | output | 5 x YW | Destination y per output |
| out_age | output | 5 x AGE_W | Incremented age per output |
| out_data | output | 5 x DATA_W | Payload per output |

## Verification
`inj_ready` is combinational and due in the same cycle as the flits, so the bench drives a new input set on the falling edge and samples `inj_ready` one nanosecond later. The port assignment is due one clock later: the bench computes its expected five outputs from its own age sort and port walk at that moment and compares them on the next falling edge, half a period after the registering edge and before the next input set is applied. Random traffic over random router positions is mixed with directed cases for age ties, ejection contention, rejected injection, corner routers and age saturation.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int NPORT = 5;
  localparam int NNET  = 4;
  localparam int P_N = 0;
  localparam int P_E = 1;
  localparam int P_S = 2;
  localparam int P_W = 3;
  localparam int P_L = 4;

  // a wins over b: older first, lower input index on equal age
  function automatic logic beats(input logic [15:0] age_a, input int idx_a,
                                 input logic [15:0] age_b, input int idx_b);
    return (age_a > age_b) || ((age_a == age_b) && (idx_a < idx_b));
  endfunction

  // choose one port: eject, then X, then Y, else lowest free network port
  function automatic logic [4:0] pick_port(input logic [4:0] req, input logic [4:0] free);
    logic [4:0] prod;
    prod = req & free;
    if (prod[P_L]) return 5'b1 << P_L;
    if (prod[P_E]) return 5'b1 << P_E;
    if (prod[P_W]) return 5'b1 << P_W;
    if (prod[P_N]) return 5'b1 << P_N;
    if (prod[P_S]) return 5'b1 << P_S;
    for (int q = 0; q < NNET; q++) begin
      if (free[q]) return 5'b1 << q;
    end
    return 5'b0;
  endfunction
endpackage

// File: rtl/defl_route_calc.sv
module defl_route_calc #(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic          multi,
  input  logic [XW-1:0] pos_x,
  input  logic [YW-1:0] pos_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output logic [4:0]    req
);
  import defl_pkg::*;
  logic go_e, go_w, go_n, go_s, at_home;

  always_comb begin
    go_e    = dst_x > pos_x;
    go_w    = dst_x < pos_x;
    go_n    = dst_y > pos_y;
    go_s    = dst_y < pos_y;
    at_home = !(go_e || go_w || go_n || go_s);
    req     = '0;
    req[P_L] = at_home;
    if (multi || !(go_e || go_w)) begin
      req[P_N] = go_n;
      req[P_S] = go_s;
    end
    req[P_E] = go_e;
    req[P_W] = go_w;
  end
endmodule

// File: rtl/defl_age_ranker.sv
module defl_age_ranker #(
  parameter int AGE_W = 6
) (
  input  logic [4:0]            valid,
  input  logic [4:0][AGE_W-1:0] age,
  output logic [4:0][2:0]       rank
);
  import defl_pkg::*;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      rank[i] = 3'd0;
      for (int j = 0; j < NPORT; j++) begin
        if (j != i && valid[j] && beats(16'(age[j]), j, 16'(age[i]), i))
          rank[i] = rank[i] + 3'd1;
      end
    end
  end
endmodule

// File: rtl/defl_port_assigner.sv
module defl_port_assigner (
  input  logic [4:0]      valid,
  input  logic [4:0][2:0] rank,
  input  logic [4:0][4:0] req,
  input  logic [3:0]      link_ok,
  output logic [4:0][4:0] gnt
);
  import defl_pkg::*;
  logic [4:0] free;
  logic [4:0] pick;

  always_comb begin
    free = {1'b1, link_ok};
    gnt  = '0;
    pick = '0;
    for (int r = 0; r < NPORT; r++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (valid[i] && (rank[i] == 3'(r))) begin
          pick   = pick_port(req[i], free);
          gnt[i] = pick;
          free   = free & ~pick;
        end
      end
    end
  end
endmodule

// File: rtl/defl_switch_alloc.sv
module defl_switch_alloc #(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  parameter int AGE_W  = 6,
  parameter int DATA_W = 16,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_multi,
  input  logic [XW-1:0]          pos_x,
  input  logic [YW-1:0]          pos_y,
  input  logic [3:0]             lnk_valid,
  input  logic [3:0][XW-1:0]     lnk_dx,
  input  logic [3:0][YW-1:0]     lnk_dy,
  input  logic [3:0][AGE_W-1:0]  lnk_age,
  input  logic [3:0][DATA_W-1:0] lnk_data,
  input  logic                   inj_valid,
  input  logic [XW-1:0]          inj_dx,
  input  logic [YW-1:0]          inj_dy,
  input  logic [AGE_W-1:0]       inj_age,
  input  logic [DATA_W-1:0]      inj_data,
  output logic                   inj_ready,
  output logic [4:0]             out_valid,
  output logic [4:0][XW-1:0]     out_dx,
  output logic [4:0][YW-1:0]     out_dy,
  output logic [4:0][AGE_W-1:0]  out_age,
  output logic [4:0][DATA_W-1:0] out_data
);
  import defl_pkg::*;

  function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] a);
    return (&a) ? a : a + 1'b1;
  endfunction

  // ---------------- edge links and injection admission ----------------
  logic [3:0] link_ok;
  logic [2:0] net_cnt, link_cnt;

  always_comb begin
    link_ok[P_N] = pos_y < YW'(MESH_Y - 1);
    link_ok[P_S] = pos_y > '0;
    link_ok[P_E] = pos_x < XW'(MESH_X - 1);
    link_ok[P_W] = pos_x > '0;
    net_cnt  = 3'($countones(lnk_valid & link_ok));
    link_cnt = 3'($countones(link_ok));
  end

  assign inj_ready = net_cnt < link_cnt;

  // ---------------- candidate vectors ----------------
  logic [4:0]             cand_v;
  logic [4:0][XW-1:0]     cand_dx;
  logic [4:0][YW-1:0]     cand_dy;
  logic [4:0][AGE_W-1:0]  cand_age;
  logic [4:0][DATA_W-1:0] cand_data;

  always_comb begin
    cand_v    = {inj_valid & inj_ready, lnk_valid & link_ok};
    cand_dx   = {inj_dx, lnk_dx};
    cand_dy   = {inj_dy, lnk_dy};
    cand_age  = {inj_age, lnk_age};
    cand_data = {inj_data, lnk_data};
  end

  // ---------------- per-input route requests ----------------
  logic [4:0][4:0] route_req;

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_route
    defl_route_calc #(.XW(XW), .YW(YW)) u_route (
      .multi (cfg_multi),
      .pos_x (pos_x),
      .pos_y (pos_y),
      .dst_x (cand_dx[gi]),
      .dst_y (cand_dy[gi]),
      .req   (route_req[gi])
    );
  end

  // ---------------- age sort and assignment ----------------
  logic [4:0][2:0] rank;
  logic [4:0][4:0] gnt;

  defl_age_ranker #(.AGE_W(AGE_W)) u_rank (
    .valid (cand_v),
    .age   (cand_age),
    .rank  (rank)
  );

  defl_port_assigner u_assign (
    .valid   (cand_v),
    .rank    (rank),
    .req     (route_req),
    .link_ok (link_ok),
    .gnt     (gnt)
  );

  // ---------------- output crossbar ----------------
  logic [4:0]             port_busy;
  logic [4:0][XW-1:0]     nx_dx;
  logic [4:0][YW-1:0]     nx_dy;
  logic [4:0][AGE_W-1:0]  nx_age;
  logic [4:0][DATA_W-1:0] nx_data;
  logic [2:0]             eject_rank;
  logic [2:0]             acc_cnt;

  always_comb begin
    port_busy  = '0;
    nx_dx      = '0;
    nx_dy      = '0;
    nx_age     = '0;
    nx_data    = '0;
    eject_rank = 3'd7;
    for (int p = 0; p < NPORT; p++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (gnt[i][p]) begin
          port_busy[p] = 1'b1;
          nx_dx[p]     = cand_dx[i];
          nx_dy[p]     = cand_dy[i];
          nx_age[p]    = age_step(cand_age[i]);
          nx_data[p]   = cand_data[i];
          if (p == P_L) eject_rank = rank[i];
        end
      end
    end
    acc_cnt = 3'($countones(cand_v));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= '0;
    else        out_valid <= port_busy;
  end

  always_ff @(posedge clk) begin
    out_dx   <= nx_dx;
    out_dy   <= nx_dy;
    out_age  <= nx_age;
    out_data <= nx_data;
  end

  // ---------------- assertions ----------------
  for (genvar gi = 0; gi < NPORT; gi++) begin : g_chk_in
    assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cand_v[gi] |-> $onehot(gnt[gi]));
    assert_no_idle_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cand_v[gi] |-> (gnt[gi] == 5'b0));
    assert_single_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_multi |-> ($countones(route_req[gi][3:0]) <= 1));
    assert_eject_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_v[gi] && route_req[gi][P_L] && !gnt[gi][P_L]) |-> (eject_rank < rank[gi]));
  end

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_chk_out
    assert_port_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt[4][gp], gnt[3][gp], gnt[2][gp], gnt[1][gp], gnt[0][gp]}));
  end

  assert_count_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(out_valid) == $past(acc_cnt)));
  assert_edge_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_valid[3:0] & ~$past(link_ok)) == 4'b0));
  assert_inject_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (net_cnt == link_cnt) |-> !cand_v[P_L]);
  assert_age_grows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_valid == 5'b0) || (out_age != '0) || (AGE_W == 0)));
endmodule

// File: tb/defl_switch_alloc_tb.sv
`timescale 1ns/1ps
module defl_switch_alloc_tb_top;
  localparam int XW = 3;
  localparam int YW = 3;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int AMAX = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_multi = 1'b0;
  logic [XW-1:0] pos_x = '0;
  logic [YW-1:0] pos_y = '0;
  logic [3:0] lnk_valid = '0;
  logic [3:0][XW-1:0] lnk_dx = '0;
  logic [3:0][YW-1:0] lnk_dy = '0;
  logic [3:0][AW-1:0] lnk_age = '0;
  logic [3:0][DW-1:0] lnk_data = '0;
  logic inj_valid = 1'b0;
  logic [XW-1:0] inj_dx = '0;
  logic [YW-1:0] inj_dy = '0;
  logic [AW-1:0] inj_age = '0;
  logic [DW-1:0] inj_data = '0;
  logic inj_ready;
  logic [4:0] out_valid;
  logic [4:0][XW-1:0] out_dx;
  logic [4:0][YW-1:0] out_dy;
  logic [4:0][AW-1:0] out_age;
  logic [4:0][DW-1:0] out_data;

  always #2.5 clk = ~clk;

  defl_switch_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_multi(cfg_multi), .pos_x(pos_x), .pos_y(pos_y),
    .lnk_valid(lnk_valid), .lnk_dx(lnk_dx), .lnk_dy(lnk_dy), .lnk_age(lnk_age),
    .lnk_data(lnk_data), .inj_valid(inj_valid), .inj_dx(inj_dx), .inj_dy(inj_dy),
    .inj_age(inj_age), .inj_data(inj_data), .inj_ready(inj_ready),
    .out_valid(out_valid), .out_dx(out_dx), .out_dy(out_dy), .out_age(out_age),
    .out_data(out_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // expected values
  bit e_rdy;
  bit e_v[5];
  int e_dx[5], e_dy[5], e_age[5], e_data[5];

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // bench model, written from the requirements
  task automatic model();
    bit lk[4];
    bit cv[5];
    bit used[5];
    bit fr[5];
    int cx[5], cy[5], ca[5], cd[5];
    int ord[5];
    int cnt, cap, mx, my;
    mx = int'(pos_x); my = int'(pos_y);
    lk[0] = my < 7; lk[1] = mx < 7; lk[2] = my > 0; lk[3] = mx > 0;
    cnt = 0; cap = 0;
    for (int i = 0; i < 4; i++) begin
      if (lk[i]) cap++;
      if (lk[i] && lnk_valid[i]) cnt++;
      cv[i] = lk[i] && lnk_valid[i];
      cx[i] = int'(lnk_dx[i]); cy[i] = int'(lnk_dy[i]);
      ca[i] = int'(lnk_age[i]); cd[i] = int'(lnk_data[i]);
    end
    e_rdy = cnt < cap;
    cv[4] = inj_valid && e_rdy;
    cx[4] = int'(inj_dx); cy[4] = int'(inj_dy); ca[4] = int'(inj_age); cd[4] = int'(inj_data);
    for (int k = 0; k < 5; k++) begin
      int best;
      best = -1;
      for (int i = 0; i < 5; i++)
        if (cv[i] && !used[i] && (best < 0 || ca[i] > ca[best])) best = i;
      ord[k] = best;
      if (best >= 0) used[best] = 1;
    end
    for (int q = 0; q < 4; q++) fr[q] = lk[q];
    fr[4] = 1;
    for (int p = 0; p < 5; p++) begin
      e_v[p] = 0; e_dx[p] = 0; e_dy[p] = 0; e_age[p] = 0; e_data[p] = 0;
    end
    for (int k = 0; k < 5; k++) begin
      int i, xd, yd, p;
      i = ord[k];
      if (i >= 0) begin
        xd = (cx[i] > mx) ? 1 : (cx[i] < mx) ? 3 : -1;
        yd = (cy[i] > my) ? 0 : (cy[i] < my) ? 2 : -1;
        p = -1;
        if (xd < 0 && yd < 0 && fr[4]) p = 4;
        if (p < 0 && xd >= 0 && fr[xd]) p = xd;
        if (p < 0 && yd >= 0 && (cfg_multi || xd < 0) && fr[yd]) p = yd;
        for (int q = 0; q < 4; q++) if (p < 0 && fr[q]) p = q;
        if (p >= 0) begin
          fr[p] = 0;
          e_v[p] = 1; e_dx[p] = cx[i]; e_dy[p] = cy[i];
          e_age[p] = (ca[i] >= AMAX) ? AMAX : ca[i] + 1;
          e_data[p] = cd[i];
        end
      end
    end
  endtask

  // inputs already driven at a falling edge
  task automatic step(string tag);
    #1;
    model();
    chk("R8", "inj_ready", longint'(inj_ready), longint'(e_rdy));
    @(negedge clk);
    for (int p = 0; p < 5; p++) begin
      chk(tag, $sformatf("valid port %0d", p), longint'(out_valid[p]), longint'(e_v[p]));
      if (e_v[p] && out_valid[p]) begin
        chk("R10", $sformatf("dx port %0d", p), longint'(out_dx[p]), longint'(e_dx[p]));
        chk("R10", $sformatf("dy port %0d", p), longint'(out_dy[p]), longint'(e_dy[p]));
        chk("R10", $sformatf("age port %0d", p), longint'(out_age[p]), longint'(e_age[p]));
        chk("R10", $sformatf("data port %0d", p), longint'(out_data[p]), longint'(e_data[p]));
      end
    end
  endtask

  task automatic clear_in();
    lnk_valid = '0; inj_valid = 1'b0;
  endtask

  task automatic put(int l, int dx, int dy, int age, int data);
    lnk_valid[l] = 1'b1; lnk_dx[l] = XW'(dx); lnk_dy[l] = YW'(dy);
    lnk_age[l] = AW'(age); lnk_data[l] = DW'(data);
  endtask

  task automatic put_inj(int dx, int dy, int age, int data);
    inj_valid = 1'b1; inj_dx = XW'(dx); inj_dy = YW'(dy);
    inj_age = AW'(age); inj_data = DW'(data);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R11", "out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "out_valid after reset, idle", longint'(out_valid), 0);

    // R2/R3: single-direction, X first
    pos_x = 3; pos_y = 3; cfg_multi = 0;
    clear_in(); put(0, 5, 6, 4, 16'h1111); step("R3");
    clear_in(); put(1, 1, 3, 4, 16'h2222); step("R2");
    clear_in(); put(3, 3, 0, 4, 16'h2323); step("R2");
    // R4: multi-direction, X taken by older flit, younger takes Y
    cfg_multi = 1;
    clear_in(); put(3, 6, 3, 20, 16'h3333); put(0, 6, 6, 5, 16'h4444); step("R4");
    // same in single-direction mode deflects instead
    cfg_multi = 0;
    clear_in(); put(3, 6, 3, 20, 16'h3333); put(0, 6, 6, 5, 16'h4444); step("R3");
    // R5: equal ages, all want east
    clear_in();
    for (int l = 0; l < 4; l++) put(l, 7, 3, 9, 16'h5000 + l);
    step("R5");
    // R6: mixed ages, all want north
    clear_in();
    put(0, 3, 7, 1, 16'h6000); put(1, 3, 7, 30, 16'h6001);
    put(2, 3, 7, 12, 16'h6002); put(3, 3, 7, 30, 16'h6003);
    step("R6");
    // R7: three flits at home contend for eject
    clear_in(); put(0, 3, 3, 10, 16'h7000); put(1, 3, 3, 20, 16'h7001); put(2, 3, 3, 15, 16'h7002);
    step("R7");
    // R8: full links, injection refused
    clear_in();
    for (int l = 0; l < 4; l++) put(l, 0, 0, 2, 16'h8000 + l);
    put_inj(7, 7, 60, 16'h8888);
    step("R8");
    // R8: three links, injection taken
    lnk_valid[2] = 1'b0; step("R8");
    // R9: corner (0,0), two links full, injection refused
    pos_x = 0; pos_y = 0;
    clear_in(); put(0, 0, 0, 3, 16'h9000); put(1, 0, 0, 4, 16'h9001);
    put(2, 5, 5, 50, 16'h9002); put(3, 5, 5, 50, 16'h9003);
    put_inj(4, 4, 1, 16'h9999);
    step("R9");
    // R9: corner (7,7), losers may not leave the mesh
    pos_x = 7; pos_y = 7;
    clear_in(); put(2, 0, 7, 8, 16'h9100); put(3, 0, 7, 9, 16'h9101); step("R9");
    clear_in(); put(3, 0, 0, 8, 16'h9200); put_inj(0, 0, 9, 16'h9201); step("R9");
    // R10: age saturates
    pos_x = 2; pos_y = 5;
    clear_in(); put(1, 0, 5, AMAX, 16'hA000); put(0, 2, 0, AMAX - 1, 16'hA001); step("R10");
    // R11: idle cycle clears outputs
    clear_in(); step("R11");

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      bit narrow;
      pos_x = XW'($urandom_range(0, 7));
      pos_y = YW'($urandom_range(0, 7));
      cfg_multi = 1'($urandom_range(0, 1));
      narrow = ($urandom_range(0, 3) == 0);
      clear_in();
      for (int l = 0; l < 4; l++) begin
        if ($urandom_range(0, 9) < 7)
          put(l, $urandom_range(0, 7), $urandom_range(0, 7),
              narrow ? $urandom_range(0, 2) : $urandom_range(0, AMAX), $urandom_range(0, 65535));
      end
      if ($urandom_range(0, 1) == 1)
        put_inj($urandom_range(0, 7), $urandom_range(0, 7),
                narrow ? $urandom_range(0, 2) : $urandom_range(0, AMAX), $urandom_range(0, 65535));
      step("R1");
    end

    // reset in mid-traffic clears outputs
    clear_in(); put(0, 0, 0, 3, 16'hB000);
    @(posedge clk); #1;
    rst_n = 1'b0; #1;
    chk("R11", "out_valid cleared by reset", longint'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule